// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative translation cache that sits beside the load/store path. Each request brings a 32-bit virtual address, the current 6-bit address-space identifier and a read/write flag. The upper 20 bits form the virtual page number and the lower 12 bits are the offset inside a 4 KB page. Every stored entry is compared at once. The registered response, one cycle later, reports a hit, a miss or a protection fault, together with the physical address and an uncached marker. Because each entry carries an address-space tag, a context switch only changes the identifier on the request, and the table does not need to be flushed.

The three most significant address bits select a region. Two of the regions are kernel physical windows, one cached and one uncached, and these skip the table. The other two regions, the user region and the kernel virtual region, are translated. A miss is only reported. A software handler then fills the table through an install port that writes a chosen index. A peek port returns the valid, referenced and dirty state of any entry, so the handler can read back the usage bits that lookups record.

Top module: `vpn_tlb`

## Requirements
- R1: After reset, no response is valid, every entry is invalid, every translated lookup misses, and each entry reads back with valid, referenced and dirty all at 0.
- R2: The low 12 address bits pass through to the low bits of the physical address unchanged. On a translated hit, the physical address is the entry's frame number followed by this offset.
- R3: A translated lookup hits only if an entry is valid and both its page number and its address-space tag equal the request's. Otherwise it misses. A valid response raises exactly one of hit, miss and fault.
- R4: The same page number stored under two different address-space tags forms two independent translations. A tag that matches no entry misses.
- R5: Region decode uses address bits 31..29. Values 0xx (the user region) and 11x (the kernel virtual region) are translated. Value 100 is an identity window, cached. Value 101 is an identity window, uncached. Both identity windows return a hit, with the physical address equal to the virtual address with bits 31..29 cleared.
- R6: On a translated hit, the uncached output is the inverse of the entry's cacheable bit.
- R7: A write to an entry marked read-only raises a fault and does not raise a hit. It leaves the dirty bit clear. A read never faults.
- R8: A translated hit sets the referenced bit of the entry. A write hit also sets its dirty bit. Misses, faults and identity-window accesses change neither bit.
- R9: When several entries match, the one with the lowest index supplies the translation.
- R10: A request sampled at one clock edge produces its response after that same edge, and the response is held for one cycle. An edge without a request gives no valid response.
- R11: An install writes every field of the chosen index and clears its referenced and dirty bits. Installing with valid at 0 removes the entry from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_va | input | 32 | Virtual address |
| req_asid | input | 6 | Current address-space tag |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Registered response valid |
| rsp_hit | output | 1 | Translation succeeded or identity window |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Write to a read-only page |
| rsp_uncached | output | 1 | Access must bypass the data cache |
| rsp_pa | output | 32 | Physical address |
| ins_en | input | 1 | Install strobe |
| ins_idx | input | 6 | Entry index to write |
| ins_valid | input | 1 | Valid bit to install |
| ins_vpn | input | 20 | Virtual page number to install |
| ins_asid | input | 6 | Address-space tag to install |
| ins_pfn | input | 20 | Physical frame number to install |
| ins_writable | input | 1 | 1 = read/write, 0 = read-only |
| ins_cacheable | input | 1 | 1 = cacheable page |
| peek_idx | input | 6 | Entry selected for read-back |
| peek_valid | output | 1 | Valid bit of the selected entry |
| peek_ref | output | 1 | Referenced bit of the selected entry |
| peek_dirty | output | 1 | Dirty bit of the selected entry |

## Verification
All 64 entries are filled with distinct page numbers, tags, frames and permission mixes. Each entry is then looked up by a read, by a write and by a neighbouring wrong tag. These three lookups separate a correct match from a tag-blind match, separate read-only pages from writable ones, and tie the referenced and dirty bits to their own entry. The even entries sit in the user region and the odd entries in the kernel virtual region, which shows that both translated regions reach the table. Addresses in the two identity windows show that the table is bypassed and that the cached and uncached windows are told apart. Duplicate entries at two indices, where the lower one is later removed, expose the match priority and the effect of an install with valid at 0.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        SEG_USER    = 2'd0,
        SEG_KPHYS_C = 2'd1,
        SEG_KPHYS_U = 2'd2,
        SEG_KVIRT   = 2'd3
    } seg_e;
endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [2:0] top_bits,
    output logic       translated,
    output logic       win_uncached
);
    seg_e seg;

    always_comb begin
        unique casez (top_bits)
            3'b0??:  seg = SEG_USER;
            3'b100:  seg = SEG_KPHYS_C;
            3'b101:  seg = SEG_KPHYS_U;
            default: seg = SEG_KVIRT;
        endcase
        translated   = (seg == SEG_USER) || (seg == SEG_KVIRT);
        win_uncached = (seg == SEG_KPHYS_U);
    end
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
    parameter int N = 64,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[k]) idx = IDX_W'(k);
        end
    end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 6,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic               wr_writable,
    input  logic               wr_cacheable,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    output logic [ENTRIES-1:0] match_vec,
    input  logic [IDX_W-1:0]   sel_idx,
    output logic [PFN_W-1:0]   sel_pfn,
    output logic               sel_writable,
    output logic               sel_cacheable,
    input  logic               upd_en,
    input  logic               upd_dirty,
    input  logic [IDX_W-1:0]   peek_idx,
    output logic               peek_valid,
    output logic               peek_ref,
    output logic               peek_dirty
);
    typedef struct packed {
        logic              vld;
        logic              ref_b;
        logic              dty;
        logic              wrb;
        logic              cab;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } ent_t;

    ent_t [ENTRIES-1:0] ent_q, ent_d;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ent_q[g].vld
                            && (ent_q[g].vpn == lk_vpn)
                            && (ent_q[g].asid == lk_asid);
    end

    always_comb begin
        ent_d = ent_q;
        if (upd_en) begin
            ent_d[sel_idx].ref_b = 1'b1;
            if (upd_dirty) ent_d[sel_idx].dty = 1'b1;
        end
        if (wr_en) begin
            ent_d[wr_idx] = '{vld: wr_valid, ref_b: 1'b0, dty: 1'b0,
                              wrb: wr_writable, cab: wr_cacheable,
                              asid: wr_asid, vpn: wr_vpn, pfn: wr_pfn};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign sel_pfn       = ent_q[sel_idx].pfn;
    assign sel_writable  = ent_q[sel_idx].wrb;
    assign sel_cacheable = ent_q[sel_idx].cab;
    assign peek_valid    = ent_q[peek_idx].vld;
    assign peek_ref      = ent_q[peek_idx].ref_b;
    assign peek_dirty    = ent_q[peek_idx].dty;
endmodule

// File: rtl/vpn_tlb.sv
module vpn_tlb #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 6,
    parameter int ENTRIES = 64,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic              rsp_uncached,
    output logic [PA_W-1:0]   rsp_pa,
    input  logic              ins_en,
    input  logic [IDX_W-1:0]  ins_idx,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASID_W-1:0] ins_asid,
    input  logic [PFN_W-1:0]  ins_pfn,
    input  logic              ins_writable,
    input  logic              ins_cacheable,
    input  logic [IDX_W-1:0]  peek_idx,
    output logic              peek_valid,
    output logic              peek_ref,
    output logic              peek_dirty
);
    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            miss;
        logic            fault;
        logic            uncached;
        logic [PA_W-1:0] pa;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic               translated, win_uncached;
    logic [ENTRIES-1:0] match_vec;
    logic               any_match;
    logic [IDX_W-1:0]   hit_idx;
    logic [PFN_W-1:0]   sel_pfn;
    logic               sel_writable, sel_cacheable;
    logic               upd_en, upd_dirty;

    tlb_seg_decode u_seg (
        .top_bits     (req_va[VA_W-1 -: 3]),
        .translated   (translated),
        .win_uncached (win_uncached)
    );

    tlb_entry_store #(
        .ENTRIES (ENTRIES), .VPN_W (VPN_W), .PFN_W (PFN_W), .ASID_W (ASID_W)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (ins_en),
        .wr_idx        (ins_idx),
        .wr_valid      (ins_valid),
        .wr_vpn        (ins_vpn),
        .wr_asid       (ins_asid),
        .wr_pfn        (ins_pfn),
        .wr_writable   (ins_writable),
        .wr_cacheable  (ins_cacheable),
        .lk_vpn        (req_va[VA_W-1:OFF_W]),
        .lk_asid       (req_asid),
        .match_vec     (match_vec),
        .sel_idx       (hit_idx),
        .sel_pfn       (sel_pfn),
        .sel_writable  (sel_writable),
        .sel_cacheable (sel_cacheable),
        .upd_en        (upd_en),
        .upd_dirty     (upd_dirty),
        .peek_idx      (peek_idx),
        .peek_valid    (peek_valid),
        .peek_ref      (peek_ref),
        .peek_dirty    (peek_dirty)
    );

    tlb_prio_enc #(.N (ENTRIES)) u_prio (
        .vec (match_vec),
        .any (any_match),
        .idx (hit_idx)
    );

    always_comb begin
        rsp_d     = '0;
        upd_en    = 1'b0;
        upd_dirty = 1'b0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (!translated) begin
                rsp_d.hit      = 1'b1;
                rsp_d.uncached = win_uncached;
                rsp_d.pa       = PA_W'(req_va[VA_W-4:0]);
            end else if (!any_match) begin
                rsp_d.miss = 1'b1;
                rsp_d.pa   = PA_W'(req_va[OFF_W-1:0]);
            end else if (req_write && !sel_writable) begin
                rsp_d.fault = 1'b1;
                rsp_d.pa    = {sel_pfn, req_va[OFF_W-1:0]};
            end else begin
                rsp_d.hit      = 1'b1;
                rsp_d.uncached = !sel_cacheable;
                rsp_d.pa       = {sel_pfn, req_va[OFF_W-1:0]};
                upd_en         = 1'b1;
                upd_dirty      = req_write;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_miss     = rsp_q.miss;
    assign rsp_fault    = rsp_q.fault;
    assign rsp_uncached = rsp_q.uncached;
    assign rsp_pa       = rsp_q.pa;
endmodule

// File: rtl/vpn_tlb_chk.sv
module vpn_tlb_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int PA_W  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_va,
    input logic            req_write,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic            rsp_uncached,
    input logic [PA_W-1:0] rsp_pa
);
    // R3: a valid response carries exactly one outcome
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    // R10: a request gives a response one edge later
    a_r10_response: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R10: no request, no response
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: page offset passes through
    a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0]));

    // R5: identity windows hit with cleared region bits
    a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_va[VA_W-1 -: 2] == 2'b10) |=>
            (rsp_hit && rsp_pa == PA_W'($past(req_va[VA_W-4:0]))
             && rsp_uncached == $past(req_va[VA_W-3])));

    // R7: reads never fault
    a_r7_read_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> !rsp_fault);
endmodule

bind vpn_tlb vpn_tlb_chk #(.VA_W (VA_W), .OFF_W (OFF_W), .PA_W (PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_va       (req_va),
    .req_write    (req_write),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_miss     (rsp_miss),
    .rsp_fault    (rsp_fault),
    .rsp_uncached (rsp_uncached),
    .rsp_pa       (rsp_pa)
);

// File: tb/vpn_tlb_bench.sv
module vpn_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [5:0]  req_asid = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_uncached;
    logic [31:0] rsp_pa;
    logic        ins_en = 1'b0;
    logic [5:0]  ins_idx = '0;
    logic        ins_valid = 1'b0;
    logic [19:0] ins_vpn = '0;
    logic [5:0]  ins_asid = '0;
    logic [19:0] ins_pfn = '0;
    logic        ins_writable = 1'b0;
    logic        ins_cacheable = 1'b0;
    logic [5:0]  peek_idx = '0;
    logic        peek_valid, peek_ref, peek_dirty;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    vpn_tlb u_vpn_tlb (.*);

    function automatic logic [19:0] vpn_of(int i);
        return {(i % 2 == 1) ? 3'b110 : 3'b010, 11'h1A3, 6'(i)};
    endfunction
    function automatic logic [19:0] pfn_of(int i);
        return 20'h01234 + 20'(i * 20'h004C1);
    endfunction
    function automatic logic [5:0] asid_of(int i);
        return 6'(63 - i);
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic install(int idx, bit v, logic [19:0] vpn, logic [5:0] asid,
                           logic [19:0] pfn, bit w, bit c);
        @(negedge clk);
        ins_en = 1'b1; ins_idx = 6'(idx); ins_valid = v; ins_vpn = vpn;
        ins_asid = asid; ins_pfn = pfn; ins_writable = w; ins_cacheable = c;
        @(negedge clk);
        ins_en = 1'b0;
    endtask

    // drive at a falling edge, sample after the next rising edge
    task automatic lookup(logic [31:0] va, logic [5:0] asid, bit wr);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_asid = asid; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] va;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
        peek_idx = 6'd7;
        #1;
        check({peek_valid, peek_ref, peek_dirty} == 3'b000, "R1 entry cleared",
              32'({peek_valid, peek_ref, peek_dirty}), 0);
        lookup({vpn_of(0), 12'h000}, asid_of(0), 1'b0);
        check(rsp_valid && rsp_miss, "R1 lookup misses after reset", 32'(rsp_miss), 1);

        // fill all entries
        for (int i = 0; i < 64; i++)
            install(i, 1'b1, vpn_of(i), asid_of(i), pfn_of(i), i[1], i[2]);

        for (int i = 0; i < 64; i++) begin
            va = {vpn_of(i), 12'(i * 37 + 5)};
            // R2 R3 R6: read hit, both translated regions (R5)
            lookup(va, asid_of(i), 1'b0);
            check(rsp_valid && rsp_hit && !rsp_miss && !rsp_fault,
                  "R3 R5 read hit", {29'd0, rsp_hit, rsp_miss, rsp_fault}, 32'h4);
            check(rsp_pa == {pfn_of(i), va[11:0]}, "R2 translated address",
                  rsp_pa, {pfn_of(i), va[11:0]});
            check(rsp_uncached == !i[2], "R6 uncached from entry",
                  32'(rsp_uncached), 32'(!i[2]));
            peek_idx = 6'(i);
            #1;
            check(peek_ref && !peek_dirty, "R8 ref set on read hit",
                  32'({peek_ref, peek_dirty}), 32'h2);
            // R4: wrong tag misses
            lookup(va, asid_of(i) ^ 6'h01, 1'b0);
            check(rsp_miss, "R4 wrong tag misses", 32'(rsp_miss), 1);
            // R7 R8: write
            lookup(va, asid_of(i), 1'b1);
            if (i[1]) begin
                check(rsp_hit && !rsp_fault, "R8 write hit", 32'({rsp_hit, rsp_fault}), 32'h2);
                #1;
                check(peek_dirty, "R8 dirty set on write hit", 32'(peek_dirty), 1);
            end else begin
                check(rsp_fault && !rsp_hit, "R7 read-only write faults",
                      32'({rsp_hit, rsp_fault}), 32'h1);
                #1;
                check(!peek_dirty, "R7 dirty stays clear", 32'(peek_dirty), 0);
            end
            // R10: idle cycle gives no response
            @(negedge clk);
            check(!rsp_valid, "R10 no response without request", 32'(rsp_valid), 0);
        end

        // R4: same page under a second tag at another index
        install(63, 1'b1, vpn_of(4), 6'h2A, 20'hABCDE, 1'b1, 1'b1);
        lookup({vpn_of(4), 12'h010}, 6'h2A, 1'b0);
        check(rsp_hit && rsp_pa == 32'hABCDE010, "R4 second tag translation", rsp_pa, 32'hABCDE010);
        lookup({vpn_of(4), 12'h010}, asid_of(4), 1'b0);
        check(rsp_hit && rsp_pa == {pfn_of(4), 12'h010}, "R4 first tag intact",
              rsp_pa, {pfn_of(4), 12'h010});

        // R5: identity windows, table untouched
        peek_idx = 6'd62;
        install(62, 1'b1, 20'h80123, 6'd0, 20'h55555, 1'b1, 1'b1);
        lookup(32'h80123ABC, 6'd0, 1'b1);
        check(rsp_hit && !rsp_uncached && rsp_pa == 32'h00123ABC, "R5 cached window",
              rsp_pa, 32'h00123ABC);
        #1;
        check(!peek_ref && !peek_dirty, "R8 window leaves entry bits", 32'({peek_ref, peek_dirty}), 0);
        lookup(32'hBFFFF004, 6'd9, 1'b0);
        check(rsp_hit && rsp_uncached && rsp_pa == 32'h1FFFF004, "R5 uncached window",
              rsp_pa, 32'h1FFFF004);

        // R9: duplicates at 10 and 40, lowest wins; R11: valid-0 install removes
        install(10, 1'b1, 20'h31111, 6'h05, 20'h0AAAA, 1'b1, 1'b1);
        install(40, 1'b1, 20'h31111, 6'h05, 20'h0BBBB, 1'b1, 1'b1);
        lookup(32'h31111123, 6'h05, 1'b0);
        check(rsp_pa == 32'h0AAAA123, "R9 lowest index wins", rsp_pa, 32'h0AAAA123);
        install(10, 1'b0, 20'h31111, 6'h05, 20'h0AAAA, 1'b1, 1'b1);
        lookup(32'h31111123, 6'h05, 1'b0);
        check(rsp_hit && rsp_pa == 32'h0BBBB123, "R11 removed entry skipped", rsp_pa, 32'h0BBBB123);

        // R11: reinstall clears usage bits
        peek_idx = 6'd5;
        install(5, 1'b1, vpn_of(5), asid_of(5), pfn_of(5), 1'b1, 1'b0);
        #1;
        check(peek_valid && !peek_ref && !peek_dirty, "R11 install clears ref and dirty",
              32'({peek_valid, peek_ref, peek_dirty}), 32'h4);

        finish_run();
    end
endmodule